// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Collector

This block gathers the interrupt sources of a two-channel serial controller into one six-bit pending register and drives a single active-high, registered interrupt request. Each channel has three sources: receive, transmit and external/status. Each source is qualified by that channel's interrupt enable byte. The receive source follows one of four policies, one of which fires only on the first character after the receiver is re-armed. A master control byte gates the request line without stopping the collection of pending bits.

External/status interrupts come from edges on a per-channel status byte. Only bits selected by a channel mask can trigger them, and the mask can never select bits 0 and 2. When such an interrupt is raised, the block captures the status byte. The masked bits then read back frozen until software issues the external/status reset. An interrupt vector output returns the base vector unchanged through channel A. Through channel B it carries a priority-encoded code of the highest pending source, in either a low or a high bit-reversed position.

In every two-bit per-channel input, bit 0 is channel A and bit 1 is channel B. Character buffering and baud timing are handled elsewhere.

Top module: `sio_irq_top`

## Requirements
- R1: While rstN is low, pending and irq are 0; each status history and each capture is cleared.
- R2: Pending bit map: A receive 5, A transmit 4, A external/status 3, B receive 2, B transmit 1, B external/status 0. A transmit-empty pulse sets the channel's transmit bit only when bit 1 of that channel's enable byte is 1. txRstCmd clears it. A set and a clear in the same cycle leave the bit set.
- R3: Receive mode is bits 4:3 of the enable byte. 0 never sets the receive bit. 1 sets it on a special-condition pulse, or on a character pulse while the first-character arm is set. 2 sets it on any character or special pulse. 3 sets it on a special pulse only. rxClrCmd clears it.
- R4: The first-character arm is 0 after reset and is set by armRxCmd. A character pulse clears it while the receive mode is not 0, so a second character in mode 1 sets nothing.
- R5: The external/status bit sets when bit 0 of the enable byte is 1 and some status bit changes between consecutive cycles under (mask AND 0xFA). Changes on status bits 0 and 2 never trigger it.
- R6: When the external/status bit sets from clear, the status byte is captured. Until extRstCmd, the read-back status shows the captured value in the bits of (mask AND 0xFA) and the live value elsewhere.
- R7: irq is registered: it takes (masterCtl bit 3) AND (OR of the pending bits being loaded). Pending bits still collect while bit 3 is 0. Setting bit 3 raises irq at that edge if anything is pending.
- R8: With vecSelB high and masterCtl bit 4 low, vector bits 3:1 carry the code of the highest pending source and the other bits follow baseVec. Priority, highest first, is A rx, A tx, A ext, B rx, B tx, B ext. The codes are A rx 6, A tx 4, A ext 5, B rx 2, B tx 0, B ext 1, none 3.
- R9: With vecSelB high and masterCtl bit 4 high, the bit-reversed code goes into vector bits 6:4 instead, and bits 7 and 3:0 follow baseVec.
- R10: With vecSelB low the vector equals baseVec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxCharEvt | input | 2 | Character-available pulse per channel |
| rxSpecEvt | input | 2 | Receive special-condition pulse per channel |
| txEmptyEvt | input | 2 | Transmit-buffer-emptied pulse per channel |
| armRxCmd | input | 2 | Arm first-character receive interrupt |
| rxClrCmd | input | 2 | Clear receive pending bit |
| txRstCmd | input | 2 | Clear transmit pending bit |
| extRstCmd | input | 2 | Clear external/status pending bit and release capture |
| intEnA | input | 8 | Channel A interrupt enable byte |
| intEnB | input | 8 | Channel B interrupt enable byte |
| extMaskA | input | STAT_W | Channel A status-change mask |
| extMaskB | input | STAT_W | Channel B status-change mask |
| statusA | input | STAT_W | Channel A live status byte |
| statusB | input | STAT_W | Channel B live status byte |
| masterCtl | input | 8 | Bit 3 master enable, bit 4 high-position vector code |
| baseVec | input | 8 | Base interrupt vector |
| vecSelB | input | 1 | Vector viewed through channel B |
| irq | output | 1 | Interrupt request, active high |
| pending | output | 6 | Pending source register |
| vecOut | output | 8 | Possibly modified vector |
| statusRdA | output | STAT_W | Channel A status read-back |
| statusRdB | output | STAT_W | Channel B status read-back |

## Verification
The hardest state to reach is a held capture. A second status edge must arrive while the external/status bit of the same channel is already pending, and the read-back must keep the first capture. The stimulus raises one status bit and then drops it before the reset command, and checks the frozen value before and after the reset. It also triggers changes on bits 0 and 2 under a mask that selects them, to show those bits are excluded. A second hard case is the first-character arm, which is never set at reset. It needs an explicit arm command, then one character that interrupts and a second one that must not.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NCH        = 2;
  localparam int SRC_PER_CH = 3;
  localparam int SRC_N      = NCH * SRC_PER_CH;
  // source offsets inside a channel's group of pending bits
  localparam int SRC_EXT = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_RX  = 2;
  // enable byte fields
  localparam int EN_EXT = 0;
  localparam int EN_TX  = 1;
  localparam int RXM_LO = 3;
  localparam int RXM_HI = 4;
  // master control fields
  localparam int MC_MIE = 3;
  localparam int MC_VHI = 4;

  typedef enum logic [1:0] {
    RXM_NONE    = 2'd0,
    RXM_FIRST   = 2'd1,
    RXM_ALL     = 2'd2,
    RXM_SPECIAL = 2'd3
  } rxMode_e;

  typedef struct packed {
    logic [SRC_N-1:0] setPend;
    logic [SRC_N-1:0] clrPend;
    logic [NCH-1:0]   snap;
    logic [NCH-1:0]   unlatch;
  } irqStrobes_t;
endpackage

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl
  import sio_irq_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] EXT_ALLOW = 'hFA
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NCH-1:0]                 rxCharEvt,
  input  logic [NCH-1:0]                 rxSpecEvt,
  input  logic [NCH-1:0]                 txEmptyEvt,
  input  logic [NCH-1:0]                 armRxCmd,
  input  logic [NCH-1:0]                 rxClrCmd,
  input  logic [NCH-1:0]                 txRstCmd,
  input  logic [NCH-1:0]                 extRstCmd,
  input  logic [NCH-1:0][7:0]            intEn,
  input  logic [NCH-1:0][STAT_W-1:0]     extMask,
  input  logic [NCH-1:0][STAT_W-1:0]     status,
  input  logic [SRC_N-1:0]               pending,
  output irqStrobes_t                    strb
);
  logic [SRC_N-1:0] setV;
  logic [SRC_N-1:0] clrV;
  logic [NCH-1:0]   snapV;
  logic [NCH-1:0]   unlatchV;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // channel A (index 0) owns the upper group of pending bits
    localparam int BASE = (NCH - 1 - ch) * SRC_PER_CH;
    logic [STAT_W-1:0] statusPrev;
    logic              armFlag;
    logic              statChg;
    logic              rxHit;
    rxMode_e           mode;

    assign mode    = rxMode_e'(intEn[ch][RXM_HI:RXM_LO]);
    assign statChg = |((status[ch] ^ statusPrev) & extMask[ch] & EXT_ALLOW);

    always_comb begin
      case (mode)
        RXM_NONE:  rxHit = 1'b0;
        RXM_FIRST: rxHit = (rxCharEvt[ch] & armFlag) | rxSpecEvt[ch];
        RXM_ALL:   rxHit = rxCharEvt[ch] | rxSpecEvt[ch];
        default:   rxHit = rxSpecEvt[ch];
      endcase
    end

    assign setV[BASE+SRC_EXT] = intEn[ch][EN_EXT] & statChg;
    assign setV[BASE+SRC_TX]  = intEn[ch][EN_TX] & txEmptyEvt[ch];
    assign setV[BASE+SRC_RX]  = rxHit;
    assign clrV[BASE+SRC_EXT] = extRstCmd[ch];
    assign clrV[BASE+SRC_TX]  = txRstCmd[ch];
    assign clrV[BASE+SRC_RX]  = rxClrCmd[ch];
    assign snapV[ch]          = setV[BASE+SRC_EXT] & ~pending[BASE+SRC_EXT];
    assign unlatchV[ch]       = extRstCmd[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusPrev <= '0;
        armFlag    <= 1'b0;
      end else begin
        statusPrev <= status[ch];
        if (armRxCmd[ch])                         armFlag <= 1'b1;
        else if (rxCharEvt[ch] && mode != RXM_NONE) armFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.setPend = setV;
    strb.clrPend = clrV;
    strb.snap    = snapV;
    strb.unlatch = unlatchV;
  end
endmodule

// File: rtl/sio_irq_dp.sv
module sio_irq_dp
  import sio_irq_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter logic [STAT_W-1:0] EXT_ALLOW = 'hFA
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  irqStrobes_t                strb,
  input  logic [NCH-1:0][STAT_W-1:0] extMask,
  input  logic [NCH-1:0][STAT_W-1:0] status,
  input  logic [7:0]                 masterCtl,
  input  logic [7:0]                 baseVec,
  input  logic                       vecSelB,
  output logic [SRC_N-1:0]           pending,
  output logic                       irq,
  output logic [7:0]                 vecOut,
  output logic [NCH-1:0][STAT_W-1:0] statusRd
);
  logic [SRC_N-1:0] pendNext;
  logic [2:0]       code;
  logic [2:0]       codeRev;

  assign pendNext = (pending & ~strb.clrPend) | strb.setPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      irq     <= 1'b0;
    end else begin
      pending <= pendNext;
      irq     <= masterCtl[MC_MIE] & (|pendNext);
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_latch
    logic [STAT_W-1:0] latchMsk;
    logic [STAT_W-1:0] latchVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchMsk <= '0;
        latchVal <= '0;
      end else if (strb.snap[ch]) begin
        latchMsk <= extMask[ch] & EXT_ALLOW;
        latchVal <= status[ch];
      end else if (strb.unlatch[ch]) begin
        latchMsk <= '0;
      end
    end

    assign statusRd[ch] = (status[ch] & ~latchMsk) | (latchVal & latchMsk);
  end

  // fixed priority: A rx, A tx, A ext, B rx, B tx, B ext
  always_comb begin
    if      (pending[5]) code = 3'd6;
    else if (pending[4]) code = 3'd4;
    else if (pending[3]) code = 3'd5;
    else if (pending[2]) code = 3'd2;
    else if (pending[1]) code = 3'd0;
    else if (pending[0]) code = 3'd1;
    else                 code = 3'd3;
  end

  assign codeRev = {code[0], code[1], code[2]};

  always_comb begin
    if (!vecSelB)                 vecOut = baseVec;
    else if (masterCtl[MC_VHI])   vecOut = {baseVec[7], codeRev, baseVec[3:0]};
    else                          vecOut = {baseVec[7:4], code, baseVec[0]};
  end
endmodule

// File: rtl/sio_irq_top.sv
module sio_irq_top
  import sio_irq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rxCharEvt,
  input  logic [1:0]        rxSpecEvt,
  input  logic [1:0]        txEmptyEvt,
  input  logic [1:0]        armRxCmd,
  input  logic [1:0]        rxClrCmd,
  input  logic [1:0]        txRstCmd,
  input  logic [1:0]        extRstCmd,
  input  logic [7:0]        intEnA,
  input  logic [7:0]        intEnB,
  input  logic [STAT_W-1:0] extMaskA,
  input  logic [STAT_W-1:0] extMaskB,
  input  logic [STAT_W-1:0] statusA,
  input  logic [STAT_W-1:0] statusB,
  input  logic [7:0]        masterCtl,
  input  logic [7:0]        baseVec,
  input  logic              vecSelB,
  output logic              irq,
  output logic [5:0]        pending,
  output logic [7:0]        vecOut,
  output logic [STAT_W-1:0] statusRdA,
  output logic [STAT_W-1:0] statusRdB
);
  localparam logic [STAT_W-1:0] EXT_ALLOW = STAT_W'('hFA);

  logic [NCH-1:0][7:0]        intEnArr;
  logic [NCH-1:0][STAT_W-1:0] maskArr;
  logic [NCH-1:0][STAT_W-1:0] statArr;
  logic [NCH-1:0][STAT_W-1:0] rdArr;
  irqStrobes_t                strb;

  assign intEnArr  = {intEnB, intEnA};
  assign maskArr   = {extMaskB, extMaskA};
  assign statArr   = {statusB, statusA};
  assign statusRdA = rdArr[0];
  assign statusRdB = rdArr[1];

  sio_irq_ctl #(.STAT_W(STAT_W), .EXT_ALLOW(EXT_ALLOW)) ctl_i (
    .clk(clk), .rstN(rstN),
    .rxCharEvt(rxCharEvt), .rxSpecEvt(rxSpecEvt), .txEmptyEvt(txEmptyEvt),
    .armRxCmd(armRxCmd), .rxClrCmd(rxClrCmd), .txRstCmd(txRstCmd), .extRstCmd(extRstCmd),
    .intEn(intEnArr), .extMask(maskArr), .status(statArr),
    .pending(pending), .strb(strb)
  );

  sio_irq_dp #(.STAT_W(STAT_W), .EXT_ALLOW(EXT_ALLOW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .extMask(maskArr), .status(statArr),
    .masterCtl(masterCtl), .baseVec(baseVec), .vecSelB(vecSelB),
    .pending(pending), .irq(irq), .vecOut(vecOut), .statusRd(rdArr)
  );
endmodule

// File: rtl/sio_irq_chk.sv
module sio_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] txEmptyEvt,
  input logic [7:0] intEnA,
  input logic [7:0] masterCtl,
  input logic [7:0] baseVec,
  input logic       vecSelB,
  input logic [5:0] pending,
  input logic       irq,
  input logic [7:0] vecOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (pending == 6'd0 && !irq));

  // R2
  tx_set_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending[4]) |-> $past(txEmptyEvt[0] && intEnA[1]));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterCtl[3] |=> !irq);

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pending != 6'd0));

  // R8
  vec_none_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecSelB && pending == 6'd0 && !masterCtl[4]) |-> vecOut[3:1] == 3'd3);

  // R9
  vec_arx_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecSelB && masterCtl[4] && pending[5]) |-> vecOut[6:4] == 3'b011);

  // R10
  vec_chan_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vecSelB |-> vecOut == baseVec);
endmodule

bind sio_irq_top sio_irq_chk chk_i (
  .clk(clk), .rstN(rstN), .txEmptyEvt(txEmptyEvt), .intEnA(intEnA),
  .masterCtl(masterCtl), .baseVec(baseVec), .vecSelB(vecSelB),
  .pending(pending), .irq(irq), .vecOut(vecOut)
);

// File: tb/sio_irq_top_tb_top.sv
module sio_irq_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rxCharEvt = '0, rxSpecEvt = '0, txEmptyEvt = '0;
  logic [1:0] armRxCmd = '0, rxClrCmd = '0, txRstCmd = '0, extRstCmd = '0;
  logic [7:0] intEnA = '0, intEnB = '0, extMaskA = '0, extMaskB = '0;
  logic [7:0] statusA = '0, statusB = '0, masterCtl = '0, baseVec = 8'h81;
  logic vecSelB = 1'b1;
  logic irq;
  logic [5:0] pending;
  logic [7:0] vecOut, statusRdA, statusRdB;

  always #10 clk = ~clk;

  sio_irq_top dut_i (
    .clk(clk), .rstN(rstN), .rxCharEvt(rxCharEvt), .rxSpecEvt(rxSpecEvt),
    .txEmptyEvt(txEmptyEvt), .armRxCmd(armRxCmd), .rxClrCmd(rxClrCmd),
    .txRstCmd(txRstCmd), .extRstCmd(extRstCmd), .intEnA(intEnA), .intEnB(intEnB),
    .extMaskA(extMaskA), .extMaskB(extMaskB), .statusA(statusA), .statusB(statusB),
    .masterCtl(masterCtl), .baseVec(baseVec), .vecSelB(vecSelB), .irq(irq),
    .pending(pending), .vecOut(vecOut), .statusRdA(statusRdA), .statusRdB(statusRdB)
  );

  typedef struct {
    logic [5:0] pend;
    logic       irq;
    logic [7:0] vec;
    logic [7:0] rdA;
    logic [7:0] rdB;
    string      tag;
  } expItem_t;

  expItem_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  logic [5:0] ePend = '0;
  logic       eIrq  = 1'b0;
  logic [7:0] eRdA  = '0;
  logic [7:0] eRdB  = '0;

  function automatic logic [7:0] refVec(logic [5:0] p, logic [7:0] b, logic hi, logic selB);
    logic [2:0] lo, h;
    if      (p[5]) begin lo = 3'd6; h = 3'd3; end
    else if (p[4]) begin lo = 3'd4; h = 3'd1; end
    else if (p[3]) begin lo = 3'd5; h = 3'd5; end
    else if (p[2]) begin lo = 3'd2; h = 3'd2; end
    else if (p[1]) begin lo = 3'd0; h = 3'd0; end
    else if (p[0]) begin lo = 3'd1; h = 3'd4; end
    else           begin lo = 3'd3; h = 3'd6; end
    if (!selB) return b;
    if (hi)    return {b[7], h, b[3:0]};
    return {b[7:4], lo, b[0]};
  endfunction

  // driver: called right after a falling edge with inputs already set
  task automatic cyc(input string tag);
    expItem_t it;
    it.pend = ePend;
    it.irq  = eIrq;
    it.vec  = refVec(ePend, baseVec, masterCtl[4], vecSelB);
    it.rdA  = eRdA;
    it.rdB  = eRdB;
    it.tag  = tag;
    q.push_back(it);
    @(negedge clk);
    rxCharEvt = '0; rxSpecEvt = '0; txEmptyEvt = '0;
    armRxCmd = '0; rxClrCmd = '0; txRstCmd = '0; extRstCmd = '0;
  endtask

  // monitor: compares between the rising and falling edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      nChecks++;
      if (pending !== it.pend || irq !== it.irq || vecOut !== it.vec ||
          statusRdA !== it.rdA || statusRdB !== it.rdB) begin
        nFails++;
        $display("FAIL %s: pend=%h irq=%b vec=%h rdA=%h rdB=%h expected pend=%h irq=%b vec=%h rdA=%h rdB=%h",
                 it.tag, pending, irq, vecOut, statusRdA, statusRdB,
                 it.pend, it.irq, it.vec, it.rdA, it.rdB);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    cyc("R1 reset state");
    rstN = 1'b1;
    cyc("R1 after release");
    // transmit
    txEmptyEvt = 2'b01;
    cyc("R2 tx ignored without enable");
    intEnA = 8'h02; txEmptyEvt = 2'b01; ePend = 6'h10;
    cyc("R2 A tx sets bit 4, R7 irq gated");
    masterCtl = 8'h08; eIrq = 1'b1;
    cyc("R7 irq on master enable");
    intEnB = 8'h02; txEmptyEvt = 2'b10; ePend = 6'h12;
    cyc("R8 A tx outranks B tx");
    txRstCmd = 2'b01; ePend = 6'h02;
    cyc("R2 tx reset A, R8 B tx code");
    masterCtl = 8'h18;
    cyc("R9 high form B tx");
    txRstCmd = 2'b10; ePend = 6'h00; eIrq = 1'b0;
    cyc("R9 high form none, R7 irq falls");
    vecSelB = 1'b0;
    cyc("R10 channel A view");
    vecSelB = 1'b1; masterCtl = 8'h08;
    // receive modes on channel A
    intEnA = 8'h08; rxCharEvt = 2'b01;
    cyc("R4 mode 1 unarmed ignores char");
    armRxCmd = 2'b01;
    cyc("R4 arm alone sets nothing");
    rxCharEvt = 2'b01; ePend = 6'h20; eIrq = 1'b1;
    cyc("R3 mode 1 armed char");
    rxClrCmd = 2'b01; ePend = 6'h00; eIrq = 1'b0;
    cyc("R3 rx clear");
    rxCharEvt = 2'b01;
    cyc("R4 second char ignored");
    rxSpecEvt = 2'b01; ePend = 6'h20; eIrq = 1'b1;
    cyc("R3 mode 1 special");
    rxClrCmd = 2'b01; ePend = 6'h00; eIrq = 1'b0;
    cyc("R3 rx clear");
    intEnA = 8'h10; rxCharEvt = 2'b01; ePend = 6'h20; eIrq = 1'b1;
    cyc("R3 mode 2 every char");
    rxClrCmd = 2'b01; txEmptyEvt = 2'b01; ePend = 6'h00; eIrq = 1'b0;
    cyc("R3 rx clear, tx not enabled in mode byte");
    intEnA = 8'h18; rxCharEvt = 2'b01;
    cyc("R3 mode 3 ignores char");
    rxSpecEvt = 2'b01; ePend = 6'h20; eIrq = 1'b1;
    cyc("R3 mode 3 special");
    rxClrCmd = 2'b01; rxSpecEvt = 2'b01; ePend = 6'h20;
    cyc("R2 set wins over clear");
    rxClrCmd = 2'b01; intEnA = 8'h00; ePend = 6'h00; eIrq = 1'b0;
    cyc("R3 rx clear");
    rxSpecEvt = 2'b01;
    cyc("R3 mode 0 ignores special");
    // master enable re-evaluation
    masterCtl = 8'h00; txEmptyEvt = 2'b10; ePend = 6'h02;
    cyc("R7 pending collects with master off");
    masterCtl = 8'h08; eIrq = 1'b1;
    cyc("R7 re-enable raises irq");
    txRstCmd = 2'b10; ePend = 6'h00; eIrq = 1'b0;
    cyc("R2 tx reset B");
    // external/status
    intEnA = 8'h01; extMaskA = 8'hFF; statusA = 8'h04; eRdA = 8'h04;
    cyc("R5 bit 2 never triggers");
    statusA = 8'h24; ePend = 6'h08; eIrq = 1'b1; eRdA = 8'h24;
    cyc("R5 bit 5 change sets A ext");
    statusA = 8'h04; eRdA = 8'h24;
    cyc("R6 read-back held while pending");
    extRstCmd = 2'b01; ePend = 6'h00; eIrq = 1'b0; eRdA = 8'h04;
    cyc("R6 ext reset releases capture");
    intEnA = 8'h00; statusA = 8'h24; eRdA = 8'h24;
    cyc("R5 ext not enabled");
    intEnA = 8'h01; extMaskA = 8'h05; statusA = 8'h21; eRdA = 8'h21;
    cyc("R5 bits 0 and 2 excluded from mask");
    intEnB = 8'h01; extMaskB = 8'h80; statusB = 8'h80; ePend = 6'h01; eIrq = 1'b1; eRdB = 8'h80;
    cyc("R5 B ext, R8 B ext code");
    intEnA = 8'h02; txEmptyEvt = 2'b01; ePend = 6'h11;
    cyc("R8 A tx over B ext");
    statusB = 8'h00; eRdB = 8'h80;
    cyc("R6 B capture held");
    extRstCmd = 2'b10; txRstCmd = 2'b01; ePend = 6'h00; eIrq = 1'b0; eRdB = 8'h00;
    cyc("R6 B released, R2 A tx cleared");
    masterCtl = 8'h18; intEnB = 8'h10; rxCharEvt = 2'b10; ePend = 6'h04; eIrq = 1'b1;
    cyc("R9 high form B rx");
    intEnA = 8'h01; extMaskA = 8'hFF; statusA = 8'h61; ePend = 6'h0C; eRdA = 8'h61;
    cyc("R9 high form A ext over B rx");
    rxClrCmd = 2'b10; extRstCmd = 2'b01; ePend = 6'h00; eIrq = 1'b0;
    cyc("R3 B rx cleared, R6 A released");
    rxSpecEvt = 2'b01; intEnA = 8'h18; masterCtl = 8'h08; ePend = 6'h20; eIrq = 1'b1;
    cyc("R8 A rx low code");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule